// File: doc/BRIEF.md
# Multi-Scheme Configuration Image Streamer

This block loads a stored configuration image into one or more downstream programmable devices. It reads the image over a simple byte-wide memory port with one cycle of read latency. It generates the configuration clock itself and places the image on up to eight data lines in one of three output schemes:

- a single serial chain;
- up to eight serial chains loaded side by side;
- a byte-wide parallel bus.

The memory holds eight image pages. Page `p` starts at word `p * PAGE_WORDS`. Its first word gives the image length in bytes, and the image bytes follow in ascending order.

After reset, a programmable power-on delay runs. When it expires, the block loads the page chosen by `page_sel`. When a load completes, the block hands the memory port to an external host. A later `reconfig` pulse takes the port back and loads the page that is selected at that moment. If the device-side status line drops during a load, the load is aborted. The block then parks with an error flag set and does not hand the port over.

The controller has eight states:

| State | Role |
|-------|------|
| ST_POR | Power-on delay |
| ST_IDLE | Parked after an abort |
| ST_LEN_REQ | Issue the read of the length word |
| ST_LEN_WAIT | Capture and clamp the length |
| ST_FETCH_REQ | Issue the read of one image byte |
| ST_FETCH_WAIT | Load the byte into the lane mux |
| ST_SHIFT | Clock out the byte's slots |
| ST_HANDOFF | Load complete; host owns the memory port |

Transitions:

- ST_POR goes to ST_LEN_REQ when the delay expires.
- ST_IDLE and ST_HANDOFF go to ST_LEN_REQ on `reconfig`.
- ST_LEN_REQ goes to ST_LEN_WAIT.
- ST_LEN_WAIT goes to ST_HANDOFF when the length is zero, and to ST_FETCH_REQ otherwise.
- ST_FETCH_REQ goes to ST_FETCH_WAIT, which goes to ST_SHIFT.
- ST_SHIFT goes to ST_FETCH_REQ after the last slot of a byte when bytes remain, and to ST_HANDOFF after the last slot of the last byte.
- Any load state (ST_LEN_REQ through ST_SHIFT) goes to ST_IDLE when `dev_status` is low.

Top module: `cfg_streamer`

## Requirements
- R1: While `rst_n` is low, `cfg_clk`, `mem_rd`, `host_grant`, `load_done` and `load_err` are 0. With `por_delay` = D, the first `mem_rd` is high in the cycle after the (D+1)-th rising clock edge following reset release, and that load uses the page on `page_sel` at that time.
- R2: A load of page p first reads address p*PAGE_WORDS (the length word). It then reads p*PAGE_WORDS+1, +2, ... in order, one address per `mem_rd` pulse, with `mem_rdata` taken one cycle after each pulse. Every read address lies inside page p.
- R3: A load makes exactly L+1 reads. L is the length word, limited to PAGE_WORDS-1. A length of 0 finishes the load with no rising edge on `cfg_clk`.
- R4: When `scheme` = 0 (single serial), each byte is sent as 8 clock slots, least significant bit first, on `cfg_data[0]`. `cfg_data[7:1]` stays 0.
- R5: When `scheme` = 1 (multi-chain serial), each byte takes one clock slot. Line k carries bit k of the byte for k <= `chains_m1`, and the lines above `chains_m1` are held at 0.
- R6: When `scheme` = 2 or 3 (byte-parallel), each byte takes one clock slot with all 8 bits on `cfg_data`.
- R7: With `clk_div` = N (0 treated as 1), every high phase of `cfg_clk` lasts N system cycles, and every low phase lasts at least N. `cfg_data` changes only while `cfg_clk` is low, so it is stable across each rising edge.
- R8: After the last slot completes, `load_done` and `host_grant` are 1, `mem_rd` is 0 and `cfg_clk` is 0, and they stay so until `reconfig`.
- R9: `reconfig` starts a load only when a load has finished or been aborted. During the power-on delay or a load, `reconfig` and changes on `page_sel`, `scheme`, `chains_m1` and `clk_div` have no effect on the load in progress.
- R10: If `dev_status` is 0 during a load, then from the next cycle `load_err` is 1, `host_grant` and `load_done` are 0, and `cfg_clk` is 0. No further reads or clocks occur until `reconfig`, which clears `load_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scheme | input | 2 | Output scheme: 0 single serial, 1 multi-chain, 2/3 byte-parallel |
| chains_m1 | input | 3 | Number of active chains minus one (multi-chain scheme) |
| page_sel | input | 3 | Image page to load |
| reconfig | input | 1 | Request a new load of the selected page |
| clk_div | input | DIV_W | Configuration clock half-period in system cycles |
| por_delay | input | POR_W | Cycles between reset release and the first load |
| dev_status | input | 1 | Device status; low aborts a load |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rdata | input | DW | Read data, valid one cycle after `mem_rd` |
| cfg_clk | output | 1 | Generated configuration clock |
| cfg_data | output | DW | Configuration data lines |
| host_grant | output | 1 | Memory port released to the external host |
| load_done | output | 1 | Last load completed |
| load_err | output | 1 | Last load aborted by `dev_status` |

## Verification
The assertions check, on every cycle:

- no reads or clocks during the power-on delay;
- data stability across each rising edge and through each high phase;
- the idle lines in serial and multi-chain schemes;
- reads confined to the latched page;
- mutual exclusion of handoff and error;
- the one-cycle abort response.

Only the bench scenarios can show the rest, which depends on the whole stream:

- the exact bit order and the number of slots per image;
- the read count under clamping and zero length;
- the measured phase lengths for each divisor;
- the power-on delay count;
- that a mid-load reconfigure request leaves the stream untouched.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    typedef enum logic [1:0] {
        MODE_SERIAL = 2'd0,
        MODE_MULTI  = 2'd1,
        MODE_BYTE   = 2'd2,
        MODE_BYTE_B = 2'd3
    } cfg_mode_e;

    typedef enum logic [2:0] {
        ST_POR        = 3'd0,
        ST_IDLE       = 3'd1,
        ST_LEN_REQ    = 3'd2,
        ST_LEN_WAIT   = 3'd3,
        ST_FETCH_REQ  = 3'd4,
        ST_FETCH_WAIT = 3'd5,
        ST_SHIFT      = 3'd6,
        ST_HANDOFF    = 3'd7
    } cfg_state_e;

endpackage

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] delay,
    output logic         expired
);
    logic [W-1:0] cnt_q;
    logic         fired_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (!fired_q) begin
            if (cnt_q == delay) begin
                fired_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    assign expired = fired_q | (cnt_q == delay);
endmodule

// File: rtl/cfg_clk_div.sv
module cfg_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             cclk,
    output logic             slot_end
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        lim    = (div == '0) ? '0 : div - DIV_W'(1);
        at_lim = (cnt_q == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cclk  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            cclk  <= 1'b0;
        end else if (at_lim) begin
            cnt_q <= '0;
            cclk  <= ~cclk;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // the high phase ends here: the next slot starts with the falling edge
    assign slot_end = run & cclk & at_lim;
endmodule

// File: rtl/cfg_lane_mux.sv
module cfg_lane_mux
    import cfg_stream_pkg::*;
#(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  din,
    input  logic          advance,
    input  cfg_mode_e     mode,
    input  logic [IW-1:0] chains,
    output logic [W-1:0]  dout,
    output logic          last
);
    logic [W-1:0]  byte_q;
    logic [IW-1:0] idx_q;
    logic [W-1:0]  lane_en;

    for (genvar k = 0; k < W; k++) begin : g_lane
        assign lane_en[k] = (int'(chains) >= k);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            byte_q <= din;
            idx_q  <= '0;
        end else if (advance) begin
            idx_q <= idx_q + IW'(1);
        end
    end

    always_comb begin
        dout = '0;
        last = 1'b1;
        unique case (mode)
            MODE_SERIAL: begin
                dout[0] = byte_q[idx_q];
                last    = (idx_q == IW'(W - 1));
            end
            MODE_MULTI: begin
                dout = byte_q & lane_en;
            end
            MODE_BYTE, MODE_BYTE_B: begin
                dout = byte_q;
            end
            default: begin
                dout = byte_q;
            end
        endcase
    end
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
    import cfg_stream_pkg::*;
#(
    parameter int DW         = 8,
    parameter int PAGE_WORDS = 32,
    parameter int DIV_W      = 8,
    parameter int POR_W      = 16,
    localparam int PAGE_AW   = $clog2(PAGE_WORDS),
    localparam int ADDR_W    = 3 + PAGE_AW,
    localparam int LIW       = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        scheme,
    input  logic [LIW-1:0]    chains_m1,
    input  logic [2:0]        page_sel,
    input  logic              reconfig,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [POR_W-1:0]  por_delay,
    input  logic              dev_status,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              cfg_clk,
    output logic [DW-1:0]     cfg_data,
    output logic              host_grant,
    output logic              load_done,
    output logic              load_err
);
    localparam logic [DW-1:0]      MAX_LEN   = DW'(PAGE_WORDS - 1);
    localparam logic [PAGE_AW-1:0] MAX_LEN_A = PAGE_AW'(PAGE_WORDS - 1);

    cfg_state_e          st, st_nxt;
    logic [2:0]          page_q;
    cfg_mode_e           mode_q;
    logic [LIW-1:0]      chains_q;
    logic [DIV_W-1:0]    div_q;
    logic [PAGE_AW-1:0]  off_q;
    logic [PAGE_AW-1:0]  remain_q;
    logic                err_q;

    logic                por_done;
    logic                cclk;
    logic                slot_end;
    logic                lane_last;
    logic [DW-1:0]       lane_data;
    logic                loading;
    logic                start_load;
    logic                abort;
    logic [PAGE_AW-1:0]  len_clamped;

    cfg_por_timer #(.W(POR_W)) u_por (
        .clk     (clk),
        .rst_n   (rst_n),
        .delay   (por_delay),
        .expired (por_done)
    );

    cfg_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      ((st == ST_SHIFT) && dev_status),
        .div      (div_q),
        .cclk     (cclk),
        .slot_end (slot_end)
    );

    cfg_lane_mux #(.W(DW)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (st == ST_FETCH_WAIT),
        .din     (mem_rdata),
        .advance ((st == ST_SHIFT) && slot_end && !lane_last),
        .mode    (mode_q),
        .chains  (chains_q),
        .dout    (lane_data),
        .last    (lane_last)
    );

    always_comb begin
        loading     = (st == ST_LEN_REQ) || (st == ST_LEN_WAIT) ||
                      (st == ST_FETCH_REQ) || (st == ST_FETCH_WAIT) ||
                      (st == ST_SHIFT);
        abort       = loading && !dev_status;
        start_load  = ((st == ST_POR) && por_done) ||
                      (((st == ST_IDLE) || (st == ST_HANDOFF)) && reconfig);
        len_clamped = (mem_rdata > MAX_LEN) ? MAX_LEN_A : mem_rdata[PAGE_AW-1:0];
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_POR:                 if (por_done) st_nxt = ST_LEN_REQ;
            ST_IDLE, ST_HANDOFF:    if (reconfig) st_nxt = ST_LEN_REQ;
            ST_LEN_REQ:             st_nxt = ST_LEN_WAIT;
            ST_LEN_WAIT:            st_nxt = (len_clamped == '0) ? ST_HANDOFF : ST_FETCH_REQ;
            ST_FETCH_REQ:           st_nxt = ST_FETCH_WAIT;
            ST_FETCH_WAIT:          st_nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (slot_end && lane_last) begin
                    st_nxt = (remain_q == '0) ? ST_HANDOFF : ST_FETCH_REQ;
                end
            end
            default:                st_nxt = ST_IDLE;
        endcase
        if (abort) st_nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_POR;
        else        st <= st_nxt;
    end

    // load context and byte bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= '0;
            mode_q   <= MODE_SERIAL;
            chains_q <= '0;
            div_q    <= '0;
            off_q    <= '0;
            remain_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (start_load) begin
                page_q   <= page_sel;
                mode_q   <= cfg_mode_e'(scheme);
                chains_q <= chains_m1;
                div_q    <= clk_div;
                err_q    <= 1'b0;
            end
            if (abort) err_q <= 1'b1;
            if (st == ST_LEN_WAIT) begin
                remain_q <= len_clamped;
                off_q    <= PAGE_AW'(1);
            end
            if (st == ST_FETCH_WAIT) begin
                remain_q <= remain_q - PAGE_AW'(1);
                off_q    <= off_q + PAGE_AW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd     = 1'b0;
        mem_addr   = '0;
        host_grant = 1'b0;
        load_done  = 1'b0;
        unique case (st)
            ST_LEN_REQ: begin
                mem_rd   = 1'b1;
                mem_addr = {page_q, {PAGE_AW{1'b0}}};
            end
            ST_FETCH_REQ: begin
                mem_rd   = 1'b1;
                mem_addr = {page_q, off_q};
            end
            ST_HANDOFF: begin
                host_grant = 1'b1;
                load_done  = 1'b1;
            end
            default: begin
                mem_rd = 1'b0;
            end
        endcase
        load_err = err_q;
        cfg_clk  = cclk;
        cfg_data = lane_data;
    end
endmodule

// File: rtl/cfg_streamer_chk.sv
module cfg_streamer_chk
    import cfg_stream_pkg::*;
#(
    parameter int DW      = 8,
    parameter int ADDR_W  = 8,
    parameter int PAGE_AW = 5,
    parameter int LIW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        st,
    input logic [1:0]        mode_q,
    input logic [LIW-1:0]    chains_q,
    input logic [2:0]        page_q,
    input logic              dev_status,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cfg_clk,
    input logic [DW-1:0]     cfg_data,
    input logic              host_grant,
    input logic              load_done,
    input logic              load_err
);
    logic [DW-1:0] allowed;
    logic          in_load;

    always_comb begin
        allowed = DW'((1 << (int'(chains_q) + 1)) - 1);
        in_load = (st >= 3'(ST_LEN_REQ)) && (st <= 3'(ST_SHIFT));
    end

    a_r1_quiet_during_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'(ST_POR)) |-> (!mem_rd && !cfg_clk && !host_grant));

    a_r2_addr_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[ADDR_W-1:PAGE_AW] == page_q));

    a_r4_serial_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'(MODE_SERIAL)) |-> (cfg_data[DW-1:1] == '0));

    a_r5_idle_chains_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'(MODE_MULTI)) |-> ((cfg_data & ~allowed) == '0));

    a_r7_data_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk) |-> $stable(cfg_data));

    a_r7_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_data));

    a_r8_handoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant |-> (!mem_rd && !cfg_clk && load_done));

    a_r10_error_excludes_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> (!host_grant && !load_done));

    a_r10_abort_response: assert property (@(posedge clk) disable iff (!rst_n)
        (in_load && !dev_status) |=> (load_err && !cfg_clk && !host_grant));
endmodule

bind cfg_streamer cfg_streamer_chk #(
    .DW      (DW),
    .ADDR_W  (ADDR_W),
    .PAGE_AW (PAGE_AW),
    .LIW     (LIW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .mode_q     (mode_q),
    .chains_q   (chains_q),
    .page_q     (page_q),
    .dev_status (dev_status),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .cfg_clk    (cfg_clk),
    .cfg_data   (cfg_data),
    .host_grant (host_grant),
    .load_done  (load_done),
    .load_err   (load_err)
);

// File: tb/sim_cfg_streamer.sv
module sim_cfg_streamer;
    localparam int PW = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] scheme;
    logic [2:0] chains_m1;
    logic [2:0] page_sel;
    logic       reconfig;
    logic [7:0] clk_div;
    logic [15:0] por_delay;
    logic       dev_status;
    logic       mem_rd;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata;
    logic       cfg_clk;
    logic [7:0] cfg_data;
    logic       host_grant;
    logic       load_done;
    logic       load_err;

    always #5 clk = ~clk;

    cfg_streamer u0 (
        .clk(clk), .rst_n(rst_n), .scheme(scheme), .chains_m1(chains_m1),
        .page_sel(page_sel), .reconfig(reconfig), .clk_div(clk_div),
        .por_delay(por_delay), .dev_status(dev_status), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .cfg_clk(cfg_clk),
        .cfg_data(cfg_data), .host_grant(host_grant), .load_done(load_done),
        .load_err(load_err)
    );

    logic [7:0] mem [0:255];
    int lens [8] = '{5, 9, 1, 17, 3, 12, 0, 200};

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    int nvec = 0;
    int nfail = 0;
    logic [7:0] cap [0:2047];
    int ncap = 0;
    int rd_idx = 0;
    int exp_base = 0;
    int eff_div = 1;
    int hi_len = 0;
    int lo_len = 0;
    logic prev_clk = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model and port observer
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_clk && !prev_clk) begin
                chk(lo_len >= eff_div, "R7 low phase length", lo_len, eff_div);
                if (ncap < 2048) cap[ncap] = cfg_data;
                ncap++;
            end
            if (!cfg_clk && prev_clk)
                chk(hi_len == eff_div, "R7 high phase length", hi_len, eff_div);
            if (cfg_clk) begin hi_len++; lo_len = 0; end
            else begin lo_len++; hi_len = 0; end
            if (mem_rd) begin
                chk(int'(mem_addr) == exp_base + rd_idx, "R2 read address",
                    int'(mem_addr), exp_base + rd_idx);
                rd_idx++;
            end
            prev_clk = cfg_clk;
        end
    end

    function automatic int exp_len(input int p);
        int raw;
        raw = int'(mem[p*PW]);
        return (raw > PW - 1) ? PW - 1 : raw;
    endfunction

    task automatic start_load(input int p, input int m, input int ch, input int dv);
        @(negedge clk);
        page_sel  = 3'(p);
        scheme    = 2'(m);
        chains_m1 = 3'(ch);
        clk_div   = 8'(dv);
        exp_base  = p * PW;
        rd_idx    = 0;
        ncap      = 0;
        eff_div   = (dv == 0) ? 1 : dv;
        reconfig  = 1'b1;
        @(negedge clk);
        reconfig  = 1'b0;
    endtask

    task automatic wait_end();
        int t = 0;
        while (!(load_done || load_err) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, "R8 load completion", t, 20000);
    endtask

    task automatic check_stream(input int p, input int m, input int ch);
        int L = exp_len(p);
        int n = (m == 0) ? L * 8 : L;
        string rq = (m == 0) ? "R4 serial bit" : ((m == 1) ? "R5 chain lines" : "R6 byte lanes");
        chk(ncap == n, "R3 clocked slot count", ncap, n);
        chk(rd_idx == L + 1, "R3 read count", rd_idx, L + 1);
        for (int i = 0; i < n && i < ncap && i < 2048; i++) begin
            logic [7:0] b;
            logic [7:0] e;
            b = mem[p*PW + 1 + ((m == 0) ? i / 8 : i)];
            if (m == 0)      e = {7'b0, b[i % 8]};
            else if (m == 1) e = b & 8'((1 << (ch + 1)) - 1);
            else             e = b;
            chk(cap[i] == e, rq, int'(cap[i]), int'(e));
        end
        chk({load_done, host_grant, mem_rd, cfg_clk, load_err} == 5'b11000,
            "R8 handoff state",
            int'({load_done, host_grant, mem_rd, cfg_clk, load_err}), 24);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int n;
        int c0;
        int r0;
        for (int a = 0; a < 256; a++) mem[a] = 8'((a * 73 + 29) ^ (a >> 2));
        for (int p = 0; p < 8; p++) mem[p*PW] = 8'(lens[p]);

        rst_n = 1'b0; scheme = 2'd0; chains_m1 = 3'd0; page_sel = 3'd2;
        reconfig = 1'b0; clk_div = 8'd1; por_delay = 16'd5; dev_status = 1'b1;
        exp_base = 2 * PW; eff_div = 1;
        repeat (3) @(negedge clk);
        chk({cfg_clk, mem_rd, host_grant, load_done, load_err} == 5'b0, "R1 reset outputs",
            int'({cfg_clk, mem_rd, host_grant, load_done, load_err}), 0);

        // R1: power-on delay
        rst_n = 1'b1;
        n = 0;
        while (n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (mem_rd) break;
        end
        chk(n == 6, "R1 power-on delay edges", n, 6);
        wait_end();
        check_stream(2, 0, 0);

        // sweep pages, schemes, chain counts and divisors (R2 R3 R4 R5 R6 R7)
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 4; m++) begin
                start_load(p, m, (p + 3 * m) % 8, (p + m) % 3);
                wait_end();
                check_stream(p, m, (p + 3 * m) % 8);
            end
        end

        // R9: reconfigure request and page change mid-load have no effect
        start_load(3, 2, 0, 2);
        repeat (20) @(negedge clk);
        page_sel = 3'd5; scheme = 2'd0; clk_div = 8'd1;
        reconfig = 1'b1;
        @(negedge clk);
        reconfig = 1'b0;
        wait_end();
        chk(ncap == exp_len(3), "R9 ignored mid-load request", ncap, exp_len(3));
        check_stream(3, 2, 0);

        // R10: abort on status low
        start_load(4, 0, 0, 1);
        repeat (30) @(negedge clk);
        dev_status = 1'b0;
        @(negedge clk);
        dev_status = 1'b1;
        chk({load_err, host_grant, load_done, cfg_clk} == 4'b1000, "R10 abort state",
            int'({load_err, host_grant, load_done, cfg_clk}), 8);
        c0 = ncap; r0 = rd_idx;
        repeat (20) @(negedge clk);
        chk(ncap == c0, "R10 no clocks after abort", ncap, c0);
        chk(rd_idx == r0, "R10 no reads after abort", rd_idx, r0);
        chk(load_err == 1'b1, "R10 error held", int'(load_err), 1);
        start_load(1, 1, 7, 1);
        wait_end();
        chk(load_err == 1'b0, "R10 error cleared by reload", int'(load_err), 0);
        check_stream(1, 1, 7);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule